// File: doc/BRIEF.md
# Self-Timed Ring Token Emulator

This block is a clocked, step-by-step logical model of a closed ring of L hold-or-copy stages of the kind used in handshake control pipelines. Each stage compares the output of the stage behind it (its forward input) with the output of the stage ahead of it (its reverse input). When the two differ, the stage copies its forward input. When they agree, it holds its value. Under this rule, tokens travel forward around the ring and bubbles travel backward. A token sits at a stage whose output differs from the output of the stage behind it.

After reset, the ring is loaded with NT tokens spread as evenly as possible. Each clock with the enable high then performs one firing step. The block exposes four results: the full stage vector, a tap taken from stage 0, the live token count, and a flag that reports whether the chosen parameters describe a ring that can oscillate. It is intended for architecture exploration and for checking the token-flow rules of a self-timed ring oscillator. Analog delay effects and jitter are not modelled.

Top module: `str_ring_emu`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, a valid ring loads its seed pattern. Stage 0 is 0, and tokens sit exactly at the positions floor(k*L/NT) for k = 0..NT-1. Stage i is the parity of the number of those positions that lie in 1..i.
- R2: `tok_count` equals the number of stages i whose output differs from the output of stage (i-1) mod L.
- R3: On an enabled step, every stage i for which stage (i-1) mod L and stage (i+1) mod L differ takes the value of stage (i-1) mod L. All other stages hold. All stages decide from the values present before the edge.
- R4: After reset, `tok_count` never changes and is always even.
- R5: While `en` is low, the stage vector does not change.
- R6: `cfg_ok` is 1 exactly when NT is even, at least 2, and at most L-1. When it is 0, the ring loads all zeros, reports a count of 0, and never changes.
- R7: `tap` always equals the output of stage 0.
- R8: When L is a multiple of 4 and NT = L/2, `tap` first toggles on the first enabled step. After that, it toggles every 2 enabled steps.
- R9: Ring lengths and token counts other than the defaults, including NT smaller than L/2, follow R1 to R3 cycle for cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; reloads the seed pattern |
| en | input | 1 | Step enable; one firing step per clock while high |
| stages | output | L | Output of every ring stage, bit i is stage i |
| tap | output | 1 | Output of stage 0 |
| tok_count | output | $clog2(L+1) | Number of tokens currently in the ring |
| cfg_ok | output | 1 | High when the parameters allow oscillation |

## Verification
Every stage is a register, so the effect of a reset or an enabled step appears on `stages` and `tap` one clock edge after that edge. `tok_count` and `cfg_ok` are combinational from the stages and the parameters. The bench drives and samples on the falling edge. It advances its own reference ring only when it has set `en` high for the next rising edge, so each comparison at a falling edge covers exactly the steps already taken. The tap period is counted in enabled steps rather than in clocks, so random pauses in `en` do not disturb that check.

// File: rtl/str_pkg.sv
// Package: shared constants and elaboration-time helpers for the ring emulator.
// Assumes ring lengths no larger than STR_MAX_L.
package str_pkg;

    localparam int STR_MAX_L = 96;

    // Oscillation is possible with an even, non-zero token count and at least one bubble.
    function automatic bit str_cfg_valid(input int l, input int nt);
        return (l >= 3) && (nt >= 2) && (nt <= l - 1) && ((nt % 2) == 0);
    endfunction

    // Seed pattern: tokens at floor(k*l/nt); stage i is the parity of token positions in 1..i.
    function automatic logic [STR_MAX_L-1:0] str_seed(input int l, input int nt);
        logic [STR_MAX_L-1:0] pat;
        pat = '0;
        if (str_cfg_valid(l, nt)) begin
            for (int i = 0; i < l; i++) begin
                int hits;
                hits = 0;
                for (int k = 1; k < nt; k++) begin
                    if ((k * l) / nt <= i) hits++;
                end
                pat[i] = hits[0];
            end
        end
        return pat;
    endfunction

endpackage

// File: rtl/str_stage.sv
// Module: one hold-or-copy ring stage.
// Copies the forward input when the forward and reverse inputs differ, otherwise holds.
// Assumes the caller gates step with the configuration check.
module str_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic seed,
    input  logic fwd,
    input  logic rev,
    output logic q
);

    // Stage register: reload on reset, copy forward value on an enabled disagreement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= seed;
        end else if (step && (fwd != rev)) begin
            q <= fwd;
        end
    end

endmodule

// File: rtl/str_token_count.sv
// Module: counts tokens, i.e. stages whose output differs from the stage behind them.
// Purely combinational; assumes CW is wide enough to hold L.
module str_token_count #(
    parameter int L  = 8,
    parameter int CW = $clog2(L + 1)
) (
    input  logic [L-1:0]  ring,
    output logic [CW-1:0] count
);

    logic [L-1:0] diff;

    // Mark every stage that disagrees with its predecessor, wrapping at stage 0.
    always_comb begin
        for (int i = 0; i < L; i++) begin
            diff[i] = ring[i] ^ ring[(i + L - 1) % L];
        end
    end

    // Sum the marks.
    always_comb begin
        count = '0;
        for (int i = 0; i < L; i++) begin
            count = count + CW'(diff[i]);
        end
    end

endmodule

// File: rtl/str_ring_emu.sv
// Module: cycle-stepped self-timed ring of L stages seeded with NT evenly spread tokens.
// One firing step per clock while en is high; all stages decide from pre-edge values.
// Assumes 4 <= L <= 96. An unusable configuration loads zeros and stays static.
module str_ring_emu
    import str_pkg::*;
#(
    parameter int L  = 8,
    parameter int NT = L / 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    output logic [L-1:0]             stages,
    output logic                     tap,
    output logic [$clog2(L+1)-1:0]   tok_count,
    output logic                     cfg_ok
);

    localparam int CW = $clog2(L + 1);
    localparam bit CFG_OK = str_cfg_valid(L, NT);
    localparam logic [STR_MAX_L-1:0] SEED_FULL = str_seed(L, NT);
    localparam logic [L-1:0] SEED = SEED_FULL[L-1:0];

    logic step;

    // Stepping is allowed only for an oscillating configuration.
    assign step = en & CFG_OK;

    // One stage per ring position: forward from behind, reverse from ahead.
    for (genvar i = 0; i < L; i++) begin : g_stage
        localparam int PREV = (i + L - 1) % L;
        localparam int NEXT = (i + 1) % L;
        str_stage u_stage (
            .clk   (clk),
            .rst_n (rst_n),
            .step  (step),
            .seed  (SEED[i]),
            .fwd   (stages[PREV]),
            .rev   (stages[NEXT]),
            .q     (stages[i])
        );
    end

    str_token_count #(
        .L  (L),
        .CW (CW)
    ) u_count (
        .ring  (stages),
        .count (tok_count)
    );

    assign tap    = stages[0];
    assign cfg_ok = CFG_OK;

endmodule

// File: rtl/str_ring_emu_chk.sv
// Module: property checker bound to the ring emulator.
// Assumes synchronous active-low reset; history is tracked only after reset release.
module str_ring_emu_chk #(
    parameter int L  = 8,
    parameter int CW = $clog2(L + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en,
    input logic [L-1:0]  stages,
    input logic          tap,
    input logic [CW-1:0] tok_count,
    input logic          cfg_ok
);

    logic [L-1:0] prev_q;
    logic         have_prev;
    logic [L-1:0] delta;
    logic [L-1:0] delta_rot;

    // Record the previous stage vector once out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_prev <= 1'b0;
            prev_q    <= '0;
        end else begin
            have_prev <= 1'b1;
            prev_q    <= stages;
        end
    end

    // Changed stages and their neighbours one position ahead.
    always_comb begin
        delta = stages ^ prev_q;
        for (int i = 0; i < L; i++) begin
            delta_rot[i] = delta[(i + 1) % L];
        end
    end

    p_count_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        have_prev |-> tok_count == $past(tok_count));

    p_count_even_r4: assert property (@(posedge clk) disable iff (!rst_n)
        have_prev |-> tok_count[0] == 1'b0);

    p_pause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(stages));

    p_static_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_ok |=> $stable(stages));

    // Neighbouring stages never fire in the same step.
    p_no_adjacent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        have_prev |-> (delta & delta_rot) == '0);

    p_moves_bounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
        have_prev |-> $countones(delta) <= int'(tok_count));

    p_tap_steps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (have_prev && !$stable(tap)) |-> $past(en));

endmodule

bind str_ring_emu str_ring_emu_chk #(
    .L  (L),
    .CW (CW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .stages    (stages),
    .tap       (tap),
    .tok_count (tok_count),
    .cfg_ok    (cfg_ok)
);

// File: tb/str_ring_emu_bench.sv
`timescale 1ns/1ps
// Bench: random enable pattern with directed pauses and resets, against a bench reference ring.
module str_ring_emu_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    // Default ring: L=8, NT=4.
    logic [7:0]  d_st;  logic d_tap;  logic [3:0] d_cnt;  logic d_ok;
    // Sparse ring: L=12, NT=4.
    logic [11:0] s_st;  logic s_tap;  logic [3:0] s_cnt;  logic s_ok;
    // Odd token count: L=6, NT=3.
    logic [5:0]  o_st;  logic o_tap;  logic [2:0] o_cnt;  logic o_ok;
    // No bubble: L=4, NT=4.
    logic [3:0]  f_st;  logic f_tap;  logic [2:0] f_cnt;  logic f_ok;
    // No token: L=4, NT=0.
    logic [3:0]  z_st;  logic z_tap;  logic [2:0] z_cnt;  logic z_ok;

    str_ring_emu u_str_ring_emu (.clk(clk), .rst_n(rst_n), .en(en),
        .stages(d_st), .tap(d_tap), .tok_count(d_cnt), .cfg_ok(d_ok));
    str_ring_emu #(.L(12), .NT(4)) u_sparse (.clk(clk), .rst_n(rst_n), .en(en),
        .stages(s_st), .tap(s_tap), .tok_count(s_cnt), .cfg_ok(s_ok));
    str_ring_emu #(.L(6), .NT(3)) u_odd (.clk(clk), .rst_n(rst_n), .en(en),
        .stages(o_st), .tap(o_tap), .tok_count(o_cnt), .cfg_ok(o_ok));
    str_ring_emu #(.L(4), .NT(4)) u_full (.clk(clk), .rst_n(rst_n), .en(en),
        .stages(f_st), .tap(f_tap), .tok_count(f_cnt), .cfg_ok(f_ok));
    str_ring_emu #(.L(4), .NT(0)) u_zero (.clk(clk), .rst_n(rst_n), .en(en),
        .stages(z_st), .tap(z_tap), .tok_count(z_cnt), .cfg_ok(z_ok));

    // Reference seed from R1: mark token positions, then prefix-xor from stage 1.
    function automatic logic [95:0] ref_seed(input int l, input int nt);
        logic [95:0] marks;
        logic [95:0] pat;
        logic acc;
        marks = '0;
        pat = '0;
        for (int k = 0; k < nt; k++) marks[(k * l) / nt] = 1'b1;
        acc = 1'b0;
        for (int i = 1; i < l; i++) begin
            acc = acc ^ marks[i];
            pat[i] = acc;
        end
        return pat;
    endfunction

    // Reference step from R3.
    function automatic logic [95:0] ref_step(input logic [95:0] c, input int l);
        logic [95:0] n;
        n = c;
        for (int i = 0; i < l; i++) begin
            if (c[(i + l - 1) % l] != c[(i + 1) % l]) n[i] = c[(i + l - 1) % l];
        end
        return n;
    endfunction

    // Reference token count from R2.
    function automatic int ref_count(input logic [95:0] c, input int l);
        int n;
        n = 0;
        for (int i = 0; i < l; i++) if (c[i] != c[(i + l - 1) % l]) n++;
        return n;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [95:0] act, input logic [95:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    logic [95:0] m_d, m_s;
    logic prev_tap;
    int steps;
    bit seen_toggle;

    // Compare both valid rings with the reference and the invalid ones with zero.
    task automatic compare_all();
        chk(d_st == m_d[7:0], "R3", "default stages", 96'(d_st), m_d);
        chk(s_st == m_s[11:0], "R9", "sparse stages", 96'(s_st), m_s);
        chk(int'(d_cnt) == 4, "R4", "default count", 96'(d_cnt), 96'd4);
        chk(int'(s_cnt) == ref_count(m_s, 12), "R2", "sparse count", 96'(s_cnt), 96'(ref_count(m_s, 12)));
        chk(d_tap == d_st[0] && s_tap == s_st[0], "R7", "tap", 96'({d_tap, s_tap}), 96'({d_st[0], s_st[0]}));
        chk(o_st == '0 && f_st == '0 && z_st == '0, "R6", "static invalid", 96'({o_st, f_st, z_st}), 96'd0);
    endtask

    // Hold reset for a few edges and reload the reference.
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        en = 1'($urandom % 2);
        repeat (2) @(negedge clk);
        m_d = ref_seed(8, 4);
        m_s = ref_seed(12, 4);
        chk(d_st == m_d[7:0], "R1", "default seed", 96'(d_st), m_d);
        chk(s_st == m_s[11:0], "R1", "sparse seed", 96'(s_st), m_s);
        rst_n = 1'b1;
        en = 1'b0;
        prev_tap = d_tap;
        steps = 0;
        seen_toggle = 1'b0;
    endtask

    // Run n random cycles, stepping the reference whenever en is set.
    task automatic run(input int n, input int en_pct);
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            compare_all();
            if (d_tap != prev_tap) begin
                if (seen_toggle) chk(steps == 2, "R8", "tap half period", 96'(steps), 96'd2);
                else chk(steps == 1, "R8", "first toggle", 96'(steps), 96'd1);
                seen_toggle = 1'b1;
                steps = 0;
                prev_tap = d_tap;
            end
            en = (($urandom % 100) < en_pct);
            if (en) begin
                m_d = ref_step(m_d, 8);
                m_s = ref_step(m_s, 12);
                steps++;
            end
        end
    endtask

    initial begin
        logic [7:0] held;
        void'($urandom(32'd20240611));
        do_reset();
        chk(d_ok == 1'b1 && s_ok == 1'b1, "R6", "valid flags", 96'({d_ok, s_ok}), 96'd3);
        chk(o_ok == 1'b0 && f_ok == 1'b0 && z_ok == 1'b0, "R6", "invalid flags", 96'({o_ok, f_ok, z_ok}), 96'd0);
        chk(o_cnt == 0 && f_cnt == 0 && z_cnt == 0, "R6", "invalid counts", 96'({o_cnt, f_cnt, z_cnt}), 96'd0);
        chk(d_st == 8'b11001100, "R1", "default literal seed", 96'(d_st), 96'hCC);
        chk(d_cnt == 4'd4, "R2", "seed count", 96'(d_cnt), 96'd4);
        run(200, 100);
        run(600, 60);
        // Directed pause (R5).
        @(negedge clk);
        en = 1'b0;
        if (d_tap != prev_tap) begin
            prev_tap = d_tap;
            steps = 0;
        end
        held = d_st;
        repeat (10) @(negedge clk);
        chk(d_st == held, "R5", "pause holds", 96'(d_st), 96'(held));
        chk(d_st == m_d[7:0], "R5", "pause matches ref", 96'(d_st), m_d);
        seen_toggle = 1'b0;
        prev_tap = d_tap;
        steps = 0;
        // Mid-run reset reload (R1), then more random steps.
        do_reset();
        run(400, 40);
        run(100, 100);
        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule